// File: doc/BRIEF.md
# JTAG Host Scan Sequencer

This block is the host side of a JTAG link. It produces TCK, TMS and TDI from the system clock and reads TDO back. One command runs one complete scan. A data-register scan or an instruction-register scan starts in Run-Test-Idle, follows the fixed TMS walk into the matching Shift state, and shifts a requested number of bits, from 1 to 32. It then leaves through Exit1 and Update and comes back to Run-Test-Idle. A third command kind walks the target TAP into Test-Logic-Reset and then parks it in Run-Test-Idle. Use it first, to bring an unknown TAP into a known state.

The bits shifted out come from a parallel write word, least significant bit first. The TDO samples are put back together into a parallel read word with the first sample at bit 0. The TCK rate comes from a divider value that is latched with each command. Each TCK half-period lasts `div+1` system clocks. Choose the divider so that TCK stays at or below one eighth of the target core clock.

Commands enter through a valid/ready handshake. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low for the whole scan, so an upstream source holds its command until the sequencer is free. The result side has no back-pressure: `done` pulses once, and `rdata` stays stable until the next command is accepted.

Top module: `jtag_scan_master`

## Requirements
- R1: A command is taken only on a cycle with `cmd_valid` and `cmd_ready` both high. `cmd_ready` is low from the next cycle until the scan has finished. Commands presented while busy are not taken and do not change the scan in progress.
- R2: TCK idles low. During a scan, each high phase and each low phase of TCK lasts `cmd_div+1` system clocks, using the divider value latched at acceptance.
- R3: TMS and TDI change only while TCK is low, so they are stable at every rising TCK edge.
- R4: `cmd_op`=00 runs a data-register scan. TMS is 1,0,0 to reach Shift-DR, then the shift bits follow, then TMS is 1,0 through Update-DR back to Run-Test-Idle: 5+length TCK cycles in total. TMS is low while idle.
- R5: `cmd_op`=01 runs an instruction-register scan. TMS is 1,1,0,0 to reach Shift-IR, then the shift bits follow, then TMS is 1,0 back to Run-Test-Idle: 6+length TCK cycles in total.
- R6: TDI carries `cmd_wdata` bits 0 upward, one per TCK cycle, for exactly `length` cycles. TMS is high together with the last bit, so the final shift edge moves the TAP to Exit1.
- R7: TDO is sampled at each rising TCK edge in the Shift state. Sample k lands in `rdata` bit k. Bits of `rdata` at or above the length are zero.
- R8: `cmd_op`=1x runs a TAP reset: TMS high for five TCK cycles, then low for one (6 cycles). The target passes through Test-Logic-Reset and ends in Run-Test-Idle, and `rdata` reads zero.
- R9: A `cmd_len` of 0 is treated as 1. A `cmd_len` above 32 is treated as 32.
- R10: `done` is high for exactly one system clock, once the sequencer is idle again with `cmd_ready` high and `rdata` final. `rdata` then holds until the next accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_op | input | 2 | 00 data scan, 01 instruction scan, 1x TAP reset |
| cmd_len | input | 6 | Bits to shift (clamped to 1..32) |
| cmd_wdata | input | 32 | Bits to send, LSB first |
| cmd_div | input | 8 | TCK half-period minus one, in system clocks |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Captured TDO bits, first sample at bit 0 |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to target |
| tdo | input | 1 | Test data from target |

## Verification
A behavioural 16-state TAP with separate data and instruction shift registers sits on the pins. It proves that each command kind leaves the target in Run-Test-Idle, with the expected number of TCK edges and Shift-state edges. Lengths 1 and 32, and the clamped values 0 and 45, show whether the last-bit TMS rise and the top-bit insertion of TDO are placed correctly. The write data and the capture data are random and different from each other. A lost, swapped or reversed bit therefore shows up on either the update side or the read side. Dividers from 0 to 7 tell the half-period timing apart from a fixed rate, and a command held valid while busy shows whether it leaks into the running scan.

// File: rtl/jtag_seq_pkg.sv
package jtag_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_HEAD,
    PH_SHIFT,
    PH_TAIL
  } seq_phase_t;

  typedef enum logic [1:0] {
    OP_DATA  = 2'b00,
    OP_INSTR = 2'b01,
    OP_RESET = 2'b10
  } scan_op_t;

  localparam int HEAD_W = 3;
  localparam logic [HEAD_W-1:0] HEAD_LAST_DATA  = 3'd2;
  localparam logic [HEAD_W-1:0] HEAD_LAST_INSTR = 3'd3;
  localparam logic [HEAD_W-1:0] HEAD_LAST_RESET = 3'd5;
  localparam logic [HEAD_W-1:0] RESET_HIGH_CNT  = 3'd5;
endpackage

// File: rtl/jtag_tck_gen.sv
module jtag_tck_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  output logic             tck,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;
  logic             tck_q;
  logic             wrap;

  assign wrap     = run && (cnt_q == div_q);
  assign rise_evt = wrap && !tck_q;
  assign fall_evt = wrap && tck_q;
  assign tck      = tck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
      tck_q <= 1'b0;
    end else begin
      if (load) div_q <= div_in;
      if (!run) begin
        cnt_q <= '0;
        tck_q <= 1'b0;
      end else if (wrap) begin
        cnt_q <= '0;
        tck_q <= ~tck_q;
      end else begin
        cnt_q <= cnt_q + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/jtag_shift_path.sv
module jtag_shift_path #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LEN_W-1:0]  len,
  input  logic              in_shift,
  input  logic              shift_rise,
  input  logic              shift_fall,
  input  logic              tdo,
  output logic              tdi,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] out_q;
  logic [DATA_W-1:0] res_q;
  logic [DATA_W-1:0] top_mask;

  assign top_mask = {{(DATA_W-1){1'b0}}, 1'b1} << (len - LEN_W'(1));
  assign tdi      = in_shift & out_q[0];
  assign rdata    = res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      res_q <= '0;
    end else if (load) begin
      out_q <= wdata;
      res_q <= '0;
    end else begin
      if (shift_fall) out_q <= out_q >> 1;
      if (shift_rise) res_q <= (res_q >> 1) | ({DATA_W{tdo}} & top_mask);
    end
  end
endmodule

// File: rtl/jtag_scan_ctrl.sv
module jtag_scan_ctrl
  import jtag_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             rise_evt,
  input  logic             fall_evt,
  output logic             cmd_ready,
  output logic             accept,
  output logic             run,
  output logic             tms,
  output logic             in_shift,
  output logic             shift_rise,
  output logic             shift_fall,
  output logic [LEN_W-1:0] len_eff,
  output logic             done
);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(DATA_W);

  seq_phase_t        phase_q;
  scan_op_t          op_q;
  logic [HEAD_W-1:0] idx_q;
  logic [LEN_W-1:0]  bit_q;
  logic [LEN_W-1:0]  len_q;
  logic              done_q;
  logic [HEAD_W-1:0] head_last;
  logic              last_bit;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] l);
    if (l == '0)          return LEN_W'(1);
    else if (l > LEN_MAX) return LEN_MAX;
    else                  return l;
  endfunction

  function automatic scan_op_t decode_op(input logic [1:0] o);
    if (o[1])      return OP_RESET;
    else if (o[0]) return OP_INSTR;
    else           return OP_DATA;
  endfunction

  assign cmd_ready  = (phase_q == PH_IDLE);
  assign accept     = cmd_valid && cmd_ready;
  assign run        = (phase_q != PH_IDLE);
  assign in_shift   = (phase_q == PH_SHIFT);
  assign shift_rise = in_shift && rise_evt;
  assign shift_fall = in_shift && fall_evt;
  assign len_eff    = len_q;
  assign done       = done_q;
  assign last_bit   = (bit_q == len_q - LEN_W'(1));

  always_comb begin
    case (op_q)
      OP_INSTR: head_last = HEAD_LAST_INSTR;
      OP_RESET: head_last = HEAD_LAST_RESET;
      default:  head_last = HEAD_LAST_DATA;
    endcase
  end

  always_comb begin
    tms = 1'b0;
    case (phase_q)
      PH_HEAD: begin
        case (op_q)
          OP_INSTR: tms = (idx_q < HEAD_W'(2));
          OP_RESET: tms = (idx_q < RESET_HIGH_CNT);
          default:  tms = (idx_q == '0);
        endcase
      end
      PH_SHIFT: tms = last_bit;
      PH_TAIL:  tms = (idx_q == '0);
      default:  tms = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      op_q    <= OP_DATA;
      idx_q   <= '0;
      bit_q   <= '0;
      len_q   <= LEN_W'(1);
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (accept) begin
            phase_q <= PH_HEAD;
            op_q    <= decode_op(cmd_op);
            len_q   <= clamp_len(cmd_len);
            idx_q   <= '0;
            bit_q   <= '0;
          end
        end
        PH_HEAD: begin
          if (fall_evt) begin
            if (idx_q == head_last) begin
              idx_q <= '0;
              if (op_q == OP_RESET) begin
                phase_q <= PH_IDLE;
                done_q  <= 1'b1;
              end else begin
                phase_q <= PH_SHIFT;
              end
            end else begin
              idx_q <= idx_q + HEAD_W'(1);
            end
          end
        end
        PH_SHIFT: begin
          if (fall_evt) begin
            if (last_bit) begin
              phase_q <= PH_TAIL;
              idx_q   <= '0;
            end else begin
              bit_q <= bit_q + LEN_W'(1);
            end
          end
        end
        PH_TAIL: begin
          if (fall_evt) begin
            if (idx_q == HEAD_W'(1)) begin
              phase_q <= PH_IDLE;
              done_q  <= 1'b1;
            end else begin
              idx_q <= idx_q + HEAD_W'(1);
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/jtag_scan_master.sv
module jtag_scan_master #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = $clog2(DATA_W + 1),
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [DIV_W-1:0]  cmd_div,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  input  logic              tdo
);
  logic             accept;
  logic             run;
  logic             rise_evt;
  logic             fall_evt;
  logic             in_shift;
  logic             shift_rise;
  logic             shift_fall;
  logic [LEN_W-1:0] len_eff;

  jtag_scan_ctrl #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_len    (cmd_len),
    .rise_evt   (rise_evt),
    .fall_evt   (fall_evt),
    .cmd_ready  (cmd_ready),
    .accept     (accept),
    .run        (run),
    .tms        (tms),
    .in_shift   (in_shift),
    .shift_rise (shift_rise),
    .shift_fall (shift_fall),
    .len_eff    (len_eff),
    .done       (done)
  );

  jtag_tck_gen #(.DIV_W(DIV_W)) u_tck (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .load     (accept),
    .div_in   (cmd_div),
    .tck      (tck),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  jtag_shift_path #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .wdata      (cmd_wdata),
    .len        (len_eff),
    .in_shift   (in_shift),
    .shift_rise (shift_rise),
    .shift_fall (shift_fall),
    .tdo        (tdo),
    .tdi        (tdi),
    .rdata      (rdata)
  );
endmodule

// File: rtl/jtag_scan_master_chk.sv
module jtag_scan_master_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic tck,
  input logic tms,
  input logic tdi,
  input logic done
);
  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  assert_idle_tck_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !tck);

  assert_pins_hold_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tck && $past(tck)) |-> ($stable(tms) && $stable(tdi)));

  assert_idle_tms_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !tms);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);
endmodule

bind jtag_scan_master jtag_scan_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .tck       (tck),
  .tms       (tms),
  .tdi       (tdi),
  .done      (done)
);

// File: tb/sim_jtag_scan_master.sv
module sim_jtag_scan_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'b00;
  logic [5:0]  cmd_len = 6'd1;
  logic [31:0] cmd_wdata = '0;
  logic [7:0]  cmd_div = '0;
  logic        done;
  logic [31:0] rdata;
  logic        tck, tms, tdi;
  logic        tdo_m = 1'b0;

  int vec_cnt = 0;
  int err_cnt = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  jtag_scan_master u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_len(cmd_len), .cmd_wdata(cmd_wdata), .cmd_div(cmd_div),
    .done(done), .rdata(rdata), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo_m)
  );

  // behavioural target TAP
  typedef enum int {TLR, RTI, SDR, CDR, SHD, E1D, PDR, E2D, UDR,
                    SIR, CIR, SHI, E1I, PIR, E2I, UIR} tap_t;
  tap_t        tap_st = TLR;
  logic [31:0] sr_dr = '0, sr_ir = '0, dr_cap = '0, ir_cap = '0;
  logic [31:0] upd_dr = '0, upd_ir = '0;
  int          rise_cnt = 0, shift_cnt = 0;
  bit          saw_tlr = 1'b0;
  longint      last_rise = 0, last_period = 0, hi_time = 0;
  int          r3_viol = 0;
  logic        tck_d = 1'b0, tms_d = 1'b0, tdi_d = 1'b0;

  function automatic tap_t tap_next(tap_t s, logic m);
    case (s)
      TLR: return m ? TLR : RTI;
      RTI: return m ? SDR : RTI;
      SDR: return m ? SIR : CDR;
      CDR: return m ? E1D : SHD;
      SHD: return m ? E1D : SHD;
      E1D: return m ? UDR : PDR;
      PDR: return m ? E2D : PDR;
      E2D: return m ? UDR : SHD;
      UDR: return m ? SDR : RTI;
      SIR: return m ? TLR : CIR;
      CIR: return m ? E1I : SHI;
      SHI: return m ? E1I : SHI;
      E1I: return m ? UIR : PIR;
      PIR: return m ? E2I : PIR;
      E2I: return m ? UIR : SHI;
      default: return m ? SDR : RTI;
    endcase
  endfunction

  always @(posedge tck) begin
    rise_cnt <= rise_cnt + 1;
    if (rise_cnt > 0) last_period <= $time - last_rise;
    last_rise <= $time;
    case (tap_st)
      CDR: sr_dr <= dr_cap;
      CIR: sr_ir <= ir_cap;
      SHD: begin sr_dr <= {tdi, sr_dr[31:1]}; shift_cnt <= shift_cnt + 1; end
      SHI: begin sr_ir <= {tdi, sr_ir[31:1]}; shift_cnt <= shift_cnt + 1; end
      UDR: upd_dr <= sr_dr;
      UIR: upd_ir <= sr_ir;
      default: ;
    endcase
    if (tap_next(tap_st, tms) == TLR) saw_tlr <= 1'b1;
    tap_st <= tap_next(tap_st, tms);
  end

  always @(negedge tck) begin
    hi_time <= $time - last_rise;
    if (tap_st == SHD) tdo_m <= sr_dr[0];
    else if (tap_st == SHI) tdo_m <= sr_ir[0];
  end

  // R3 monitor on the pins: no TMS/TDI change while TCK stays high
  always @(negedge clk) begin
    if (tck && tck_d && (tms !== tms_d || tdi !== tdi_d)) r3_viol++;
    tck_d <= tck; tms_d <= tms; tdi_d <= tdi;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vec_cnt++;
    if (!ok) begin
      err_cnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lmask(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction

  function automatic int clamp(input int l);
    return (l == 0) ? 1 : ((l > 32) ? 32 : l);
  endfunction

  task automatic do_scan(input int op, input int len, input logic [31:0] wd,
                         input int div, input logic [31:0] cap, input bit hold_junk);
    int eff, cyc, exp_rises;
    logic [31:0] held;
    eff = clamp(len);
    dr_cap = cap; ir_cap = ~cap;
    rise_cnt = 0; shift_cnt = 0; saw_tlr = 1'b0;
    upd_dr = 32'hDEAD_BEEF; upd_ir = 32'hDEAD_BEEF;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_len = 6'(len); cmd_wdata = wd; cmd_div = 8'(div);
    @(negedge clk);
    chk(cmd_ready == 1'b0, "R1 busy after accept", cmd_ready, 0);
    if (hold_junk) begin
      cmd_wdata = ~wd; cmd_op = 2'b10; cmd_len = 6'd7;
      repeat (3) @(negedge clk);
    end
    cmd_valid = 1'b0;
    cyc = 0;
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    chk(done == 1'b1, "R10 done seen", done, 1);
    chk(cmd_ready == 1'b1, "R10 idle at done", cmd_ready, 1);
    chk(tap_st == RTI, "R4 R5 R8 target back in Run-Test-Idle", tap_st, RTI);
    exp_rises = (op >= 2) ? 6 : ((op == 1) ? 6 + eff : 5 + eff);
    chk(rise_cnt == exp_rises, (op == 1) ? "R5 TCK cycle count" : "R4 R8 TCK cycle count",
        rise_cnt, exp_rises);
    chk(last_period == 4 * 2 * (div + 1), "R2 TCK period", last_period, 8 * (div + 1));
    chk(hi_time == 4 * (div + 1), "R2 TCK high time", hi_time, 4 * (div + 1));
    if (op >= 2) begin
      chk(saw_tlr, "R8 passed Test-Logic-Reset", saw_tlr, 1);
      chk(rdata == 32'h0, "R8 rdata zero", rdata, 0);
    end else begin
      chk(shift_cnt == eff, "R6 R9 shift edges", shift_cnt, eff);
      if (op == 0) begin
        chk((upd_dr >> (32 - eff)) == (wd & lmask(eff)), "R6 data bits delivered",
            upd_dr >> (32 - eff), wd & lmask(eff));
        chk(rdata == (cap & lmask(eff)), "R7 captured read data", rdata, cap & lmask(eff));
      end else begin
        chk((upd_ir >> (32 - eff)) == (wd & lmask(eff)), "R5 R6 instruction bits delivered",
            upd_ir >> (32 - eff), wd & lmask(eff));
        chk(rdata == (~cap & lmask(eff)), "R7 captured instruction status", rdata, ~cap & lmask(eff));
      end
    end
    held = rdata;
    @(negedge clk);
    chk(done == 1'b0, "R10 done single cycle", done, 0);
    repeat (4) @(negedge clk);
    chk(rdata == held, "R10 rdata holds", rdata, held);
    chk(tck == 1'b0 && tms == 1'b0, "R2 R4 idle pins low", {tck, tms}, 0);
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(32'd90210);
    repeat (4) @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 ready after reset", cmd_ready, 1);
    chk(tck == 1'b0 && done == 1'b0, "R2 reset pins", {tck, done}, 0);
    rst_n = 1'b1;
    do_scan(2, 5, 32'h0, 0, 32'h0, 0);                     // R8 reset from TLR
    do_scan(0, 32, 32'hA5A5_5A5A, 0, 32'h1234_5678, 0);    // R4 R6 R7 full word
    do_scan(1, 4, 32'h0000_0006, 7, 32'hFFFF_FFF5, 0);     // R5 short IR, slow
    do_scan(0, 1, 32'h1, 3, 32'h0000_0001, 0);             // R6 single bit
    do_scan(0, 0, 32'h0, 2, 32'hFFFF_FFFF, 0);             // R9 zero length
    do_scan(1, 45, 32'hC3C3_3C3C, 1, 32'h0F0F_F0F0, 0);    // R9 over-length
    do_scan(0, 16, 32'h0000_BEEF, 0, 32'hCAFE_F00D, 1);    // R1 held command ignored
    do_scan(3, 9, 32'hFFFF_FFFF, 1, 32'h5, 0);             // R8 op 11 is reset
    for (int i = 0; i < 40; i++) begin
      do_scan($urandom % 3, 1 + ($urandom % 32), $urandom, $urandom % 8, $urandom,
              ($urandom % 4) == 0);
    end
    chk(r3_viol == 0, "R3 TMS/TDI stable while TCK high", r3_viol, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
    end
  end

  initial begin
    #(4 * 190000);
    if (!finished) begin
      finished = 1'b1;
      vec_cnt++; err_cnt++;
      $display("FAIL watchdog R10 actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
    end
  end
endmodule